// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core that uses overlapping register windows. The core always addresses 32 architectural registers with a 5-bit index. The block maps that index onto a larger physical store. The store holds two banks of eight global registers (a normal bank and an alternate bank) and a ring of windowed segments, eight registers per segment, two segments per window.

A window-pointer input selects which segments the out, local and in groups reach. Adjacent windows share storage: the ins of one window are the same registers as the outs of the window before it in the ring. A flag switches the global group over to the alternate bank.

The block has two combinational read ports and one write port that updates on the clock edge. For every port it also reports the flattened physical index the architectural index resolves to, so that rename or trace logic can see the real storage location.

A new pointer or flag value is captured on a clock edge. It steers the accesses that come after that edge.

Top module: `winreg_file`

## Requirements
- R1: Index bits [4:3] choose the group: 0 is globals, 1 is outs, 2 is locals, 3 is ins. Index bits [2:0] choose the register within the group and appear unchanged as bits [2:0] of the reported physical index.
- R2: With effective pointer c, let base = ((NWIN − c) mod NWIN)·2. Outs use segment base, locals use segment base+1, and ins use segment (base+2) mod 2·NWIN. Segment s reports physical index 16 + 8·s + register.
- R3: The ins of window c and the outs of window (c−1) mod NWIN name the same storage. This includes the wrap between pointer 1 and pointer 0, where the ins reach segment 0.
- R4: With the alternate flag clear, globals report physical index 0..7. With the flag set, they report 8..15. The two banks hold separate values.
- R5: A synchronous active-high reset clears every register to zero, sets the effective pointer to 0 and selects the normal globals. This holds whatever the pointer and flag inputs are during reset.
- R6: Physical registers 0 and 8 (global 0 of each bank) always read as zero. Writes to them are dropped, and they are never forwarded.
- R7: A pointer or flag value applied in one cycle steers accesses from the next cycle onward. A write in the cycle of the change lands in the mapping that was in force before the change.
- R8: When the write port and a read port resolve to the same physical index in the same cycle, the read returns the write data.
- R9: A pointer input of NWIN or more behaves exactly as the input modulo NWIN.
- R10: Data written on a clock edge is returned by any later read of that physical index until it is overwritten or the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cwp_i | input | CWP_W | Window pointer, captured on each edge |
| alt_glob_i | input | 1 | Alternate global bank select, captured on each edge |
| rd0_idx_i | input | 5 | Read port 0 architectural index |
| rd0_data_o | output | DATA_W | Read port 0 data |
| rd0_phys_o | output | FLAT_W | Read port 0 physical index |
| rd1_idx_i | input | 5 | Read port 1 architectural index |
| rd1_data_o | output | DATA_W | Read port 1 data |
| rd1_phys_o | output | FLAT_W | Read port 1 physical index |
| we_i | input | 1 | Write enable |
| wa_idx_i | input | 5 | Write architectural index |
| wd_i | input | DATA_W | Write data |
| wa_phys_o | output | FLAT_W | Write port physical index |

## Verification
The bench targets the ring wrap, where the ins at pointer 1 must reach segment 0 and so meet the outs at pointer 0. A design with an off-by-one wrap would show the written value under the wrong window, or not at all.

It writes in the same cycle that the pointer or the bank flag changes. A design that applies the change at once would put the data into the new window.

It makes same-cycle write/read collisions and collisions on the hard-wired zero registers. A broken bypass would return stale data, and a bypass that ignores the zero rule would leak a nonzero value out of register 0.

It drives pointers above the window count, and it holds nonzero pointer and flag values through reset. This exposes a missing modulo or a reset mapping that follows the inputs.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  localparam int REGS_PER_GRP = 8;
  localparam int NRM_GLB_BASE = 0;
  localparam int ALT_GLB_BASE = 8;
  localparam int WIN_BASE     = 16;
  localparam int ARCH_IDX_W   = 5;
endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
  parameter int NWIN   = 6,
  parameter int CQ_W   = 3,
  parameter int FLAT_W = 7
) (
  input  logic [CQ_W-1:0]                  cwp,
  input  logic                             alt,
  input  logic [winreg_pkg::ARCH_IDX_W-1:0] idx,
  output logic [FLAT_W-1:0]                flat
);
  import winreg_pkg::*;

  localparam int NSEG = 2 * NWIN;

  int base;
  int seg;

  always_comb begin
    base = ((NWIN - int'(cwp)) % NWIN) * 2;
    seg  = 0;
    flat = '0;
    unique case (grp_e'(idx[4:3]))
      GRP_GLB: flat = FLAT_W'(alt ? ALT_GLB_BASE : NRM_GLB_BASE) | FLAT_W'(idx[2:0]);
      GRP_OUT: seg = base;
      GRP_LOC: seg = base + 1;
      GRP_IN:  seg = (base + 2) % NSEG;
    endcase
    if (idx[4:3] != 2'd0)
      flat = FLAT_W'(WIN_BASE + seg * REGS_PER_GRP) | FLAT_W'(idx[2:0]);
  end
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
  parameter int DATA_W = 64,
  parameter int NPHYS  = 112,
  parameter int FLAT_W = 7,
  parameter int NRD    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [FLAT_W-1:0]             wflat,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NRD-1:0][FLAT_W-1:0]    rflat,
  output logic [NRD-1:0][DATA_W-1:0]    rdata
);
  import winreg_pkg::*;

  logic [DATA_W-1:0] mem [NPHYS];
  logic              wr_ok;

  function automatic logic is_hardzero(input logic [FLAT_W-1:0] f);
    return (f == FLAT_W'(NRM_GLB_BASE)) || (f == FLAT_W'(ALT_GLB_BASE));
  endfunction

  assign wr_ok = we && !is_hardzero(wflat);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPHYS; k++) mem[k] <= '0;
    end else if (wr_ok) begin
      mem[wflat] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (is_hardzero(rflat[p]))
        rdata[p] = '0;
      else if (wr_ok && (wflat == rflat[p]))
        rdata[p] = wdata;
      else
        rdata[p] = mem[rflat[p]];
    end
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DATA_W = 64,
  parameter int NWIN   = 6,
  parameter int CWP_W  = 5,
  parameter int NPHYS  = 16 + 16 * NWIN,
  parameter int FLAT_W = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic              alt_glob_i,
  input  logic [4:0]        rd0_idx_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic [FLAT_W-1:0] rd0_phys_o,
  input  logic [4:0]        rd1_idx_i,
  output logic [DATA_W-1:0] rd1_data_o,
  output logic [FLAT_W-1:0] rd1_phys_o,
  input  logic              we_i,
  input  logic [4:0]        wa_idx_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [FLAT_W-1:0] wa_phys_o
);
  localparam int CQ_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int NRD   = 2;
  localparam int NPORT = NRD + 1;

  logic [CQ_W-1:0] cwp_q;
  logic            alt_q;
  logic [CQ_W-1:0] cwp_red;

  assign cwp_red = CQ_W'(int'(cwp_i) % NWIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q <= '0;
      alt_q <= 1'b0;
    end else begin
      cwp_q <= cwp_red;
      alt_q <= alt_glob_i;
    end
  end

  logic [NPORT-1:0][4:0]        port_idx;
  logic [NPORT-1:0][FLAT_W-1:0] port_flat;
  logic [NRD-1:0][FLAT_W-1:0]   rd_flat;
  logic [NRD-1:0][DATA_W-1:0]   rd_data;

  assign port_idx = {wa_idx_i, rd1_idx_i, rd0_idx_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    winreg_map #(.NWIN(NWIN), .CQ_W(CQ_W), .FLAT_W(FLAT_W)) u_map (
      .cwp  (cwp_q),
      .alt  (alt_q),
      .idx  (port_idx[p]),
      .flat (port_flat[p])
    );
  end

  assign rd_flat = {port_flat[1], port_flat[0]};

  winreg_store #(.DATA_W(DATA_W), .NPHYS(NPHYS), .FLAT_W(FLAT_W), .NRD(NRD)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we_i),
    .wflat (port_flat[2]),
    .wdata (wd_i),
    .rflat (rd_flat),
    .rdata (rd_data)
  );

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];
  assign rd0_phys_o = port_flat[0];
  assign rd1_phys_o = port_flat[1];
  assign wa_phys_o  = port_flat[2];
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int DATA_W = 64,
  parameter int NWIN   = 6,
  parameter int CWP_W  = 5,
  parameter int NPHYS  = 112,
  parameter int FLAT_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [CWP_W-1:0]  cwp_i,
  input logic              alt_glob_i,
  input logic [4:0]        rd0_idx_i,
  input logic [DATA_W-1:0] rd0_data_o,
  input logic [FLAT_W-1:0] rd0_phys_o,
  input logic              we_i,
  input logic [DATA_W-1:0] wd_i,
  input logic [FLAT_W-1:0] wa_phys_o
);
  logic [1:0] arm_cnt;
  always_ff @(posedge clk) begin
    if (rst) arm_cnt <= '0;
    else if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
  end

  logic wa_live;
  assign wa_live = we_i && (wa_phys_o != FLAT_W'(0)) && (wa_phys_o != FLAT_W'(8));

  // R6
  hardzero_read_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd0_phys_o == FLAT_W'(0)) || (rd0_phys_o == FLAT_W'(8))) |-> (rd0_data_o == '0));

  // R8
  write_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (wa_live && (wa_phys_o == rd0_phys_o)) |-> (rd0_data_o == wd_i));

  // R4
  glob_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx_i[4:3] == 2'd0) |-> ((rd0_phys_o < FLAT_W'(16)) && (rd0_phys_o[2:0] == rd0_idx_i[2:0])));

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx_i[4:3] != 2'd0) |-> ((rd0_phys_o >= FLAT_W'(16)) && (int'(rd0_phys_o) < NPHYS)
                                  && (rd0_phys_o[2:0] == rd0_idx_i[2:0])));

  // R10
  write_persist_chk: assert property (@(posedge clk) disable iff (rst)
    ((arm_cnt != 2'd0) && $past(wa_live) && (rd0_phys_o == $past(wa_phys_o))
     && !(we_i && (wa_phys_o == rd0_phys_o))) |-> (rd0_data_o == $past(wd_i)));

  // R7
  map_steady_chk: assert property (@(posedge clk) disable iff (rst)
    ((arm_cnt == 2'd3) && ($past(cwp_i) == $past(cwp_i, 2)) && ($past(alt_glob_i) == $past(alt_glob_i, 2))
     && (rd0_idx_i == $past(rd0_idx_i))) |-> (rd0_phys_o == $past(rd0_phys_o)));
endmodule

bind winreg_file winreg_chk #(
  .DATA_W(DATA_W), .NWIN(NWIN), .CWP_W(CWP_W), .NPHYS(NPHYS), .FLAT_W(FLAT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cwp_i      (cwp_i),
  .alt_glob_i (alt_glob_i),
  .rd0_idx_i  (rd0_idx_i),
  .rd0_data_o (rd0_data_o),
  .rd0_phys_o (rd0_phys_o),
  .we_i       (we_i),
  .wd_i       (wd_i),
  .wa_phys_o  (wa_phys_o)
);

// File: tb/winreg_file_bench.sv
module winreg_file_bench;
  localparam int DATA_W = 64;
  localparam int NWIN   = 6;
  localparam int CWP_W  = 5;
  localparam int NPHYS  = 16 + 16 * NWIN;
  localparam int FLAT_W = $clog2(NPHYS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CWP_W-1:0]  cwp_i = '0;
  logic              alt_glob_i = 1'b0;
  logic [4:0]        rd0_idx_i = '0, rd1_idx_i = '0, wa_idx_i = '0;
  logic [DATA_W-1:0] rd0_data_o, rd1_data_o, wd_i = '0;
  logic [FLAT_W-1:0] rd0_phys_o, rd1_phys_o, wa_phys_o;
  logic              we_i = 1'b0;

  always #10 clk = ~clk;

  winreg_file #(.DATA_W(DATA_W), .NWIN(NWIN), .CWP_W(CWP_W)) u_winreg_file (
    .clk(clk), .rst(rst), .cwp_i(cwp_i), .alt_glob_i(alt_glob_i),
    .rd0_idx_i(rd0_idx_i), .rd0_data_o(rd0_data_o), .rd0_phys_o(rd0_phys_o),
    .rd1_idx_i(rd1_idx_i), .rd1_data_o(rd1_data_o), .rd1_phys_o(rd1_phys_o),
    .we_i(we_i), .wa_idx_i(wa_idx_i), .wd_i(wd_i), .wa_phys_o(wa_phys_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DATA_W-1:0] mdl [NPHYS];
  int cur_cwp = 0;
  bit cur_alt = 0;

  function automatic int fmap(int cw, bit al, logic [4:0] idx);
    int base, seg;
    base = ((NWIN - cw) % NWIN) * 2;
    case (idx[4:3])
      2'd0: return (al ? 8 : 0) + int'(idx[2:0]);
      2'd1: seg = base;
      2'd2: seg = base + 1;
      default: seg = (base + 2) % (2 * NWIN);
    endcase
    return 16 + 8 * seg + int'(idx[2:0]);
  endfunction

  function automatic logic [DATA_W-1:0] fexp(int f, bit we, int fw, logic [DATA_W-1:0] wd);
    if (f == 0 || f == 8) return '0;
    if (we && fw == f) return wd;
    return mdl[f];
  endfunction

  task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int cw, bit al, logic [4:0] i0, logic [4:0] i1,
                     bit we, logic [4:0] wi, logic [DATA_W-1:0] wd, string tag);
    int f0, f1, fw;
    logic [DATA_W-1:0] e0, e1;
    cwp_i = CWP_W'(cw); alt_glob_i = al; rd0_idx_i = i0; rd1_idx_i = i1;
    we_i = we; wa_idx_i = wi; wd_i = wd;
    #5;
    f0 = fmap(cur_cwp, cur_alt, i0);
    f1 = fmap(cur_cwp, cur_alt, i1);
    fw = fmap(cur_cwp, cur_alt, wi);
    e0 = fexp(f0, we, fw, wd);
    e1 = fexp(f1, we, fw, wd);
    check(int'(rd0_phys_o) == f0, tag, DATA_W'(rd0_phys_o), DATA_W'(f0));
    check(int'(rd1_phys_o) == f1, tag, DATA_W'(rd1_phys_o), DATA_W'(f1));
    check(int'(wa_phys_o) == fw, tag, DATA_W'(wa_phys_o), DATA_W'(fw));
    check(rd0_data_o == e0, tag, rd0_data_o, e0);
    check(rd1_data_o == e1, tag, rd1_data_o, e1);
    @(posedge clk); #1;
    if (we && fw != 0 && fw != 8) mdl[fw] = wd;
    cur_cwp = cw % NWIN;
    cur_alt = al;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; we_i = 1'b1; wd_i = '1; cwp_i = 5'd3; alt_glob_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; we_i = 1'b0;
    for (int k = 0; k < NPHYS; k++) mdl[k] = '0;
    cur_cwp = 0; cur_alt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cw;
    bit al;
    logic [4:0] i0;
    void'($urandom(32'd20240611));
    do_reset();
    // R5: inputs held at pointer 3 / alternate bank during reset; mapping must be pointer 0, normal bank
    cyc(5, 1, 5'd1, 5'd9, 1'b0, 5'd0, '0, "R5");
    cyc(0, 0, 5'd17, 5'd25, 1'b0, 5'd0, '0, "R5 R1");
    // R6: write to register 0 dropped and not forwarded
    cyc(0, 0, 5'd0, 5'd0, 1'b1, 5'd0, 64'hDEAD_BEEF_0000_0001, "R6");
    cyc(0, 1, 5'd0, 5'd1, 1'b0, 5'd0, '0, "R6");
    cyc(0, 1, 5'd0, 5'd0, 1'b1, 5'd0, 64'h1234, "R6");
    // R8: same-cycle forward on both ports
    cyc(0, 0, 5'd9, 5'd9, 1'b1, 5'd9, 64'hA5A5_0000_FFFF_0009, "R8");
    cyc(0, 0, 5'd9, 5'd10, 1'b0, 5'd0, '0, "R10");
    // R4: alternate bank separate from normal bank
    cyc(0, 1, 5'd3, 5'd3, 1'b1, 5'd3, 64'h0000_0000_0000_0A03, "R4");
    cyc(0, 1, 5'd3, 5'd3, 1'b1, 5'd3, 64'h0000_0000_0000_0B03, "R4");
    cyc(0, 0, 5'd3, 5'd4, 1'b0, 5'd0, '0, "R4");
    cyc(0, 0, 5'd3, 5'd4, 1'b0, 5'd0, '0, "R4");
    // R3: ring wrap, ins at pointer 1 meet outs at pointer 0 (segment 0)
    cyc(1, 0, 5'd24, 5'd8, 1'b0, 5'd0, '0, "R3");
    cyc(1, 0, 5'd24, 5'd8, 1'b1, 5'd24, 64'hC0DE_0000_0000_0018, "R3");
    cyc(0, 0, 5'd24, 5'd8, 1'b0, 5'd0, '0, "R3");
    cyc(0, 0, 5'd8, 5'd24, 1'b0, 5'd0, '0, "R3");
    // R9: pointer above window count behaves as its remainder
    cyc(NWIN + 1, 0, 5'd8, 5'd24, 1'b0, 5'd0, '0, "R9");
    cyc(31, 0, 5'd8, 5'd24, 1'b0, 5'd0, '0, "R9");
    cyc(31, 0, 5'd16, 5'd31, 1'b0, 5'd0, '0, "R9");
    // R7: write in the cycle of a pointer change uses the old mapping
    cyc(2, 0, 5'd16, 5'd16, 1'b1, 5'd16, 64'h7777_0000_0000_0010, "R7");
    cyc(0, 1, 5'd16, 5'd1, 1'b1, 5'd1, 64'h0000_0000_0000_7701, "R7");
    cyc(0, 0, 5'd16, 5'd1, 1'b0, 5'd0, '0, "R7");
    cyc(0, 0, 5'd16, 5'd1, 1'b0, 5'd0, '0, "R7");
    // random phase
    cw = 0; al = 0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 8 == 0) cw = int'($urandom % 32);
      if ($urandom % 10 == 0) al = ~al;
      i0 = 5'($urandom);
      cyc(cw, al, i0, 5'($urandom), ($urandom % 2) == 0,
          ($urandom % 4 == 0) ? i0 : 5'($urandom), {$urandom, $urandom}, "R2 R10 R8");
    end
    // R5: second reset clears everything written
    do_reset();
    for (int k = 0; k < 32; k++) begin
      cyc(k % 8, k[3], 5'(k), 5'(31 - k), 1'b0, 5'd0, '0, "R5");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule